// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a 16-bit down-counting interval timer with an 8-bit true prescaler in front of it. The prescaler counts down to zero, then the main counter takes one step and the prescaler restarts from its reload value. When both reach zero while the timer is enabled, the block emits a single-cycle timeout pulse and reloads both stages. In periodic mode it then keeps running. In one-shot mode it halts until the enable input is dropped and raised again.

Configuration arrives over a narrow write port: an address, a data word and a write strobe. Through it the block takes the interval, the match pair (counter match and prescaler match), the prescale value, a direct counter write and the mode bits. The match pair and the interval/prescale pair each have their own update policy: a new value either takes effect at once or waits for the next timeout. A match pulse fires when the live counter and prescaler equal the active match pair. The live state is presented as one packed word, and the active prescale value is presented as a snapshot.

Top module: `presc_down_timer`

## Requirements
- R1: While counting is enabled, the prescaler decrements by one each cycle. When it is zero and the counter is non-zero, the counter decrements by one and the prescaler reloads the active prescale value. A full period is therefore (interval+1)*(prescale+1) enabled cycles.
- R2: `valueOut` carries the counter in bits 15:0, the live prescaler in bits 23:16, and zero in bits 31:24.
- R3: A write to address 4 places wrData[15:0] into the counter and wrData[23:16] into the prescaler at the next clock edge. It takes priority over counting and timeout, and it works even while the timer is disabled.
- R4: When counting is enabled and the counter and prescaler are both zero, the next edge reloads the counter with the active interval (address 0) and the prescaler with the active prescale (address 2). `tmoPulse` is high for exactly the cycle after that edge.
- R5: When counting is enabled, the counter equals the active match value (address 1) and the prescaler equals the active prescale-match value (address 3), `matchPulse` is high in the following cycle.
- R6: Mode bit 0 (address 5) selects periodic (1) or one-shot (0). In one-shot mode, counting stops after a timeout and stays stopped until `enIn` is seen low for at least one edge.
- R7: Mode bit 1 selects when the match and prescale-match values take effect: 0 means at the next edge after the write, 1 means at the next timeout.
- R8: Mode bit 2 applies the same choice to the interval and prescale values. `preSnap` always shows the active prescale value.
- R9: While `enIn` is low and no counter write occurs, `valueOut` holds and neither pulse fires.
- R10: After reset, the counter, prescaler, all configuration values and the mode are zero, and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enIn | input | 1 | Count enable |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 3 | Write address (0 interval, 1 match, 2 prescale, 3 prescale-match, 4 counter value, 5 mode) |
| wrData | input | 32 | Write data |
| valueOut | output | 32 | Live counter and prescaler, packed |
| preSnap | output | 8 | Active prescale value |
| tmoPulse | output | 1 | Single-cycle timeout pulse |
| matchPulse | output | 1 | Single-cycle match pulse |

## Verification
The bench measures the spacing of consecutive timeouts. A divider that steps the counter when it should reload the prescaler, or that counts the reload cycle twice, shows up as a period other than (interval+1)*(prescale+1). It writes new match and prescale values while the timer runs in the deferred policies. A block that applies them at once, or that never applies them, diverges from the reference model before the next timeout, and the prescale snapshot is checked against both the old and the new value. It exercises the one-shot halt and its release through a low `enIn`, holding with enable low, and counter writes that coincide with counting. A long random phase then mixes mode changes and writes that land on timeout edges.

// File: rtl/presc_timer_pkg.sv
package presc_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int MODE_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_LOAD   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MATCH  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PRE    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PMATCH = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_VALUE  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd5;

  localparam int MODE_PERIODIC    = 0;
  localparam int MODE_MATCH_DEFER = 1;
  localparam int MODE_LOAD_DEFER  = 2;

  // strobes from control to datapath, at most one is high per cycle
  typedef struct packed {
    logic valueLoad;
    logic reload;
    logic cntStep;
    logic preStep;
  } tmrStrobe_t;
endpackage

// File: rtl/presc_timer_slot.sv
// Shadow/active pair for one configuration value with a selectable update policy.
module presc_timer_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrHit,
  input  logic         defer,
  input  logic         commit,
  input  logic [W-1:0] wrVal,
  output logic [W-1:0] activeVal
);
  logic [W-1:0] shadowQ;
  logic [W-1:0] activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
      activeQ <= '0;
    end else begin
      if (wrHit) shadowQ <= wrVal;
      if (wrHit && !defer) activeQ <= wrVal;
      else if (commit) activeQ <= shadowQ;
    end
  end

  assign activeVal = activeQ;
endmodule

// File: rtl/presc_timer_dp.sv
module presc_timer_dp
  import presc_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrCnt,
  input  logic [PRE_W-1:0] wrPre,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [PRE_W-1:0] preVal,
  input  logic [CNT_W-1:0] matchVal,
  input  logic [PRE_W-1:0] pmatchVal,
  output logic [CNT_W-1:0] cntQ,
  output logic [PRE_W-1:0] preQ,
  output logic             cntZero,
  output logic             preZero,
  output logic             matchHit
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [CNT_W-1:0] cntD;
  logic [PRE_W-1:0] preD;

  always_comb begin
    cntD = cntQ;
    preD = preQ;
    if (strobe.valueLoad) begin
      cntD = wrCnt;
      preD = wrPre;
    end else if (strobe.reload) begin
      cntD = loadVal;
      preD = preVal;
    end else if (strobe.cntStep) begin
      cntD = cntQ - CNT_ONE;
      preD = preVal;
    end else if (strobe.preStep) begin
      preD = preQ - PRE_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      preQ <= '0;
    end else begin
      cntQ <= cntD;
      preQ <= preD;
    end
  end

  assign cntZero  = (cntQ == '0);
  assign preZero  = (preQ == '0);
  assign matchHit = (cntQ == matchVal) && (preQ == pmatchVal);
endmodule

// File: rtl/presc_timer_ctrl.sv
module presc_timer_ctrl
  import presc_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              cntZero,
  input  logic              preZero,
  input  logic              matchHit,
  output tmrStrobe_t        strobe,
  output logic              hitLoad,
  output logic              hitMatch,
  output logic              hitPre,
  output logic              hitPmatch,
  output logic              matchDefer,
  output logic              loadDefer,
  output logic              tmoPulse,
  output logic              matchPulse
);
  logic [MODE_W-1:0] modeQ;
  logic              haltedQ;
  logic              go;
  logic              hitValue;
  logic              hitMode;

  assign hitLoad   = wrEn && (wrAddr == ADDR_LOAD);
  assign hitMatch  = wrEn && (wrAddr == ADDR_MATCH);
  assign hitPre    = wrEn && (wrAddr == ADDR_PRE);
  assign hitPmatch = wrEn && (wrAddr == ADDR_PMATCH);
  assign hitValue  = wrEn && (wrAddr == ADDR_VALUE);
  assign hitMode   = wrEn && (wrAddr == ADDR_MODE);

  assign matchDefer = modeQ[MODE_MATCH_DEFER];
  assign loadDefer  = modeQ[MODE_LOAD_DEFER];

  assign go = enIn && !haltedQ;

  always_comb begin
    strobe           = '0;
    strobe.valueLoad = hitValue;
    if (go && !hitValue) begin
      strobe.reload  = cntZero && preZero;
      strobe.cntStep = preZero && !cntZero;
      strobe.preStep = !preZero;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= '0;
      haltedQ    <= 1'b0;
      tmoPulse   <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      if (hitMode) modeQ <= modeIn;
      if (!enIn) haltedQ <= 1'b0;
      else if (strobe.reload && !modeQ[MODE_PERIODIC]) haltedQ <= 1'b1;
      tmoPulse   <= strobe.reload;
      matchPulse <= go && !hitValue && matchHit;
    end
  end
endmodule

// File: rtl/presc_down_timer.sv
module presc_down_timer
  import presc_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] valueOut,
  output logic [PRE_W-1:0]  preSnap,
  output logic              tmoPulse,
  output logic              matchPulse
);
  localparam int PAD_W = DATA_W - CNT_W - PRE_W;

  tmrStrobe_t       strobe;
  logic             hitLoad, hitMatch, hitPre, hitPmatch;
  logic             matchDefer, loadDefer;
  logic             cntZero, preZero, matchHit;
  logic [CNT_W-1:0] loadAct, matchAct, cntQ;
  logic [PRE_W-1:0] preAct, pmatchAct, preQ;

  presc_timer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enIn(enIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .modeIn(wrData[MODE_W-1:0]), .cntZero(cntZero), .preZero(preZero),
    .matchHit(matchHit), .strobe(strobe), .hitLoad(hitLoad),
    .hitMatch(hitMatch), .hitPre(hitPre), .hitPmatch(hitPmatch),
    .matchDefer(matchDefer), .loadDefer(loadDefer),
    .tmoPulse(tmoPulse), .matchPulse(matchPulse)
  );

  presc_timer_slot #(.W(CNT_W)) loadSlot_i (
    .clk(clk), .rstN(rstN), .wrHit(hitLoad), .defer(loadDefer),
    .commit(strobe.reload), .wrVal(wrData[CNT_W-1:0]), .activeVal(loadAct)
  );
  presc_timer_slot #(.W(PRE_W)) preSlot_i (
    .clk(clk), .rstN(rstN), .wrHit(hitPre), .defer(loadDefer),
    .commit(strobe.reload), .wrVal(wrData[PRE_W-1:0]), .activeVal(preAct)
  );
  presc_timer_slot #(.W(CNT_W)) matchSlot_i (
    .clk(clk), .rstN(rstN), .wrHit(hitMatch), .defer(matchDefer),
    .commit(strobe.reload), .wrVal(wrData[CNT_W-1:0]), .activeVal(matchAct)
  );
  presc_timer_slot #(.W(PRE_W)) pmatchSlot_i (
    .clk(clk), .rstN(rstN), .wrHit(hitPmatch), .defer(matchDefer),
    .commit(strobe.reload), .wrVal(wrData[PRE_W-1:0]), .activeVal(pmatchAct)
  );

  presc_timer_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrCnt(wrData[CNT_W-1:0]), .wrPre(wrData[CNT_W+PRE_W-1:CNT_W]),
    .loadVal(loadAct), .preVal(preAct), .matchVal(matchAct),
    .pmatchVal(pmatchAct), .cntQ(cntQ), .preQ(preQ),
    .cntZero(cntZero), .preZero(preZero), .matchHit(matchHit)
  );

  assign valueOut = {{PAD_W{1'b0}}, preQ, cntQ};
  assign preSnap  = preAct;
endmodule

module presc_down_timer_chk
  import presc_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              enIn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] valueOut,
  input logic              tmoPulse,
  input logic              matchPulse
);
  localparam int LIVE_W = CNT_W + PRE_W;

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    valueOut[DATA_W-1:LIVE_W] == '0);

  a_r3_value_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_VALUE) |=> valueOut[LIVE_W-1:0] == $past(wrData[LIVE_W-1:0]));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!enIn && !(wrEn && wrAddr == ADDR_VALUE)) |=> ($stable(valueOut) && !tmoPulse && !matchPulse));

  a_r4_tmo_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    tmoPulse |-> $past(enIn));

  a_r5_match_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(enIn));
endmodule

bind presc_down_timer presc_down_timer_chk #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rstN(rstN), .enIn(enIn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .valueOut(valueOut), .tmoPulse(tmoPulse),
  .matchPulse(matchPulse)
);

// File: tb/presc_down_timer_tb_top.sv
module presc_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] valueOut;
  logic [7:0]  preSnap;
  logic        tmoPulse, matchPulse;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string curReq = "R10";

  // reference model state
  int mCnt, mPre, mMode, mHalt;
  int mLoadS, mLoadA, mPreS, mPreA, mMatchS, mMatchA, mPmS, mPmA;
  bit mTmo, mMatch, modelOn = 1'b0;

  presc_down_timer dut_i (
    .clk(clk), .rstN(rstN), .enIn(enIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .valueOut(valueOut), .preSnap(preSnap),
    .tmoPulse(tmoPulse), .matchPulse(matchPulse)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int slotNext(bit hit, bit defer, bit commit, int d, int shadow, int act);
    if (hit && !defer) return d;
    if (commit) return shadow;
    return act;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPre = 0; mMode = 0; mHalt = 0;
      mLoadS = 0; mLoadA = 0; mPreS = 0; mPreA = 0;
      mMatchS = 0; mMatchA = 0; mPmS = 0; mPmA = 0;
      mTmo = 0; mMatch = 0;
    end else begin
      bit go, vw, tmo, mt, ldDef, mtDef;
      int dLo, dPre;
      go = enIn && (mHalt == 0);
      vw = wrEn && (wrAddr == 3'd4);
      tmo = go && !vw && mCnt == 0 && mPre == 0;
      mt = go && !vw && mCnt == mMatchA && mPre == mPmA;
      ldDef = ((mMode >> 2) & 1) != 0;
      mtDef = ((mMode >> 1) & 1) != 0;
      dLo = int'(wrData[15:0]);
      dPre = int'(wrData[7:0]);
      if (vw) begin
        mCnt = int'(wrData[15:0]); mPre = int'(wrData[23:16]);
      end else if (tmo) begin
        mCnt = mLoadA; mPre = mPreA;
      end else if (go && mPre == 0) begin
        mCnt = mCnt - 1; mPre = mPreA;
      end else if (go) begin
        mPre = mPre - 1;
      end
      if (!enIn) mHalt = 0;
      else if (tmo && (mMode & 1) == 0) mHalt = 1;
      mLoadA  = slotNext(wrEn && wrAddr == 3'd0, ldDef, tmo, dLo, mLoadS, mLoadA);
      mPreA   = slotNext(wrEn && wrAddr == 3'd2, ldDef, tmo, dPre, mPreS, mPreA);
      mMatchA = slotNext(wrEn && wrAddr == 3'd1, mtDef, tmo, dLo, mMatchS, mMatchA);
      mPmA    = slotNext(wrEn && wrAddr == 3'd3, mtDef, tmo, dPre, mPmS, mPmA);
      if (wrEn && wrAddr == 3'd0) mLoadS = dLo;
      if (wrEn && wrAddr == 3'd2) mPreS = dPre;
      if (wrEn && wrAddr == 3'd1) mMatchS = dLo;
      if (wrEn && wrAddr == 3'd3) mPmS = dPre;
      if (wrEn && wrAddr == 3'd5) mMode = int'(wrData[2:0]);
      mTmo = tmo; mMatch = mt;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (modelOn && rstN && !done) begin
      check(curReq, "R2 valueOut", int'(valueOut), (mPre << 16) | mCnt);
      check(curReq, "R4 tmoPulse", int'(tmoPulse), int'(mTmo));
      check(curReq, "R5 matchPulse", int'(matchPulse), int'(mMatch));
      check(curReq, "R8 preSnap", int'(preSnap), mPreA);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTmo(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (tmoPulse) break;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int first, second, cyc, nMatch, held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "valueOut", int'(valueOut), 0);
    check("R10", "preSnap", int'(preSnap), 0);
    check("R10", "pulses", int'({tmoPulse, matchPulse}), 0);
    modelOn = 1'b1;

    // R1 R4 periodic divider period
    curReq = "R1 R4";
    wr(3'd0, 32'd5);
    wr(3'd2, 32'd2);
    wr(3'd5, 32'd1);
    enIn = 1'b1;
    first = -1; second = -1; cyc = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      cyc++;
      if (tmoPulse) begin
        if (first < 0) first = cyc;
        else if (second < 0) second = cyc;
      end
    end
    check("R1 R4", "timeout spacing", second - first, 18);

    // R5 match pair, once per period
    curReq = "R5";
    wr(3'd1, 32'd3);
    wr(3'd3, 32'd1);
    nMatch = 0;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk);
      if (matchPulse) nMatch++;
    end
    check("R5", "matches in two periods", nMatch, 2);

    // R7 deferred match update
    curReq = "R7";
    wr(3'd5, 32'd3);
    wr(3'd1, 32'd4);
    wr(3'd3, 32'd0);
    repeat (40) @(negedge clk);

    // R8 deferred load/prescale update and snapshot
    curReq = "R8";
    wr(3'd5, 32'd5);
    wr(3'd2, 32'd0);
    check("R8", "snapshot before timeout", int'(preSnap), 2);
    waitTmo(40);
    check("R8", "snapshot after timeout", int'(preSnap), 0);
    repeat (10) @(negedge clk);

    // R6 one-shot halts until enable drops
    curReq = "R6";
    enIn = 1'b0;
    wr(3'd5, 32'd0);
    wr(3'd0, 32'd4);
    wr(3'd2, 32'd1);
    wr(3'd4, 32'h0000_0002);
    enIn = 1'b1;
    @(negedge clk);
    waitTmo(40);
    check("R6", "one-shot timeout seen", int'(tmoPulse), 1);
    held = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (valueOut != 32'h0001_0004 || tmoPulse) held = 0;
    end
    check("R6", "one-shot holds", held, 1);
    enIn = 1'b0;
    @(negedge clk);
    enIn = 1'b1;
    @(negedge clk);
    check("R6", "resumes after enable toggle", int'(valueOut), 32'h0000_0004);

    // R9 hold while disabled
    curReq = "R9";
    wr(3'd5, 32'd1);
    repeat (7) @(negedge clk);
    enIn = 1'b0;
    @(negedge clk);
    first = int'(valueOut);
    held = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (int'(valueOut) != first || tmoPulse || matchPulse) held = 0;
    end
    check("R9", "held while disabled", held, 1);

    // R2 R3 counter write, disabled and while counting
    curReq = "R3";
    wr(3'd4, 32'hFFAB_1234);
    check("R2 R3", "written value layout", int'(valueOut), 32'h00AB_1234);
    enIn = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'd4, 32'h0003_0007);
    check("R3", "write overrides counting", int'(valueOut), 32'h0003_0007);

    // mixed random phase
    curReq = "R1 R4 R5 R6 R7 R8";
    for (int i = 0; i < 4000; i++) begin
      enIn = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 7) == 0) begin
        logic [2:0] a;
        a = 3'($urandom_range(0, 5));
        wrEn = 1'b1; wrAddr = a;
        wrData = (a == 3'd4) ? {8'h00, 8'($urandom_range(0, 3)), 16'($urandom_range(0, 9))}
                             : 32'($urandom_range(0, 7));
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk);
    end
    wrEn = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule